// File: doc/BRIEF.md
# RAM Bank Select Command Lines

This block keeps track of which RAM bank, or group of banks, the processor is currently addressing. It drives one active-high command line per bank. A designate-bank operation loads a small bank register from the low bits of the accumulator. From then on, every command window opened by the cycle sequencer asserts the lines decoded from that register. A following address-send or memory-write then reaches only the selected bank or banks, and the 4-bit accumulator value lands at the location most recently sent, inside that bank.

The lines are decoded bit by bit rather than by a one-of-N decoder. Register bit k drives line k+1, so setting several bits selects several banks at once. Line 0 is driven only when every register bit is clear, which means it is never active together with any other line. A plain status output reports when two or more lines would be active, so that multi-bank selection is visible to the surrounding logic.

The load strobe, the command window and the status output are plain control pins. No data stream crosses this block, so no valid/ready handshake is used and there is no back-pressure.

Top module: `bank_select_lines`

## Requirements
- R1: While reset is asserted, and after it is released with no load, the bank register is zero: with the window open, `bank_cmd` is 4'b0001 and `multi_sel` is 0.
- R2: The register changes only on a clock edge at which `ld_en` is high. The new value shows on the outputs after that edge. With `ld_en` low, the outputs keep their previous value.
- R3: Only `ld_val[2:0]` is stored. `ld_val[3]` has no effect on `bank_cmd` or on `multi_sel`.
- R4: With the window open, the register values 3'b000, 3'b001, 3'b010 and 3'b100 drive `bank_cmd` to 4'b0001, 4'b0010, 4'b0100 and 4'b1000 respectively. Bit i of `bank_cmd` is line i.
- R5: When several register bits are set, every matching line among lines 1 to 3 is asserted together. For example, 3'b011 gives 4'b0110 and 3'b111 gives 4'b1110.
- R6: Line 0 (`bank_cmd[0]`) is high only when all register bits are zero, and it is never high together with any other line.
- R7: When `cmd_win` is low, all of `bank_cmd` is low, whatever the register holds.
- R8: `multi_sel` is high exactly when two or more register bits are set, whether `cmd_win` is high or low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Designate-bank strobe: load the register this cycle |
| ld_val | input | 4 | Accumulator value; low 3 bits are loaded |
| cmd_win | input | 1 | Command window from the cycle sequencer |
| bank_cmd | output | 4 | Active-high bank command lines, bit i = line i |
| multi_sel | output | 1 | High when more than one line would be active |

## Verification
The bench builds the block with its default parameters: a 3-bit bank register fed from a 4-bit accumulator. With these values all eight register codes can be covered exhaustively, including every multi-bank combination. Because the accumulator is one bit wider than the register, a set upper bit can be driven to show that it leaves both the lines and the status output unchanged. The window is also closed while multi-bank codes are held, which separates the gating of the lines from the ungated status flag.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  // Default widths shared by the block, its checker and its bench.
  localparam int DEF_SEL_W = 3;
  localparam int DEF_ACC_W = 4;
endpackage

// File: rtl/bsel_reg.sv
module bsel_reg #(
  parameter int SEL_W = bsel_pkg::DEF_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [SEL_W-1:0] ld_lo,
  output logic [SEL_W-1:0] sel_q
);
  // Bank register: cleared by reset, written only on the designate strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (ld_en) begin
      sel_q <= ld_lo;
    end
  end
endmodule

// File: rtl/bsel_decode.sv
module bsel_decode #(
  parameter int SEL_W = bsel_pkg::DEF_SEL_W,
  localparam int LINES = SEL_W + 1
) (
  input  logic [SEL_W-1:0] sel_q,
  output logic [LINES-1:0] lines,
  output logic             multi
);
  // Line 0 only when nothing else is selected.
  assign lines[0] = ~|sel_q;

  // Each register bit drives its own line independently.
  for (genvar i = 1; i < LINES; i++) begin : g_line
    assign lines[i] = sel_q[i-1];
  end

  // Clearing the lowest set bit leaves something only if two or more were set.
  logic [SEL_W-1:0] less_one;
  assign less_one = sel_q - SEL_W'(1);
  assign multi    = |(sel_q & less_one);
endmodule

// File: rtl/bsel_gate.sv
module bsel_gate #(
  parameter int LINES = bsel_pkg::DEF_SEL_W + 1
) (
  input  logic             cmd_win,
  input  logic [LINES-1:0] lines,
  output logic [LINES-1:0] bank_cmd
);
  // Command lines are only driven inside the sequencer's window.
  always_comb begin
    bank_cmd = '0;
    if (cmd_win) begin
      bank_cmd = lines;
    end
  end
endmodule

// File: rtl/bank_select_lines.sv
module bank_select_lines #(
  parameter int SEL_W = bsel_pkg::DEF_SEL_W,
  parameter int ACC_W = bsel_pkg::DEF_ACC_W,
  localparam int LINES = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [ACC_W-1:0] ld_val,
  input  logic             cmd_win,
  output logic [LINES-1:0] bank_cmd,
  output logic             multi_sel
);
  logic [SEL_W-1:0] sel_q;
  logic [LINES-1:0] lines;

  // Accumulator bits above the register width are deliberately dropped.
  if (ACC_W > SEL_W) begin : g_drop_hi
    logic unused_hi;
    assign unused_hi = ^ld_val[ACC_W-1:SEL_W];
  end

  bsel_reg #(.SEL_W(SEL_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_en (ld_en),
    .ld_lo (ld_val[SEL_W-1:0]),
    .sel_q (sel_q)
  );

  bsel_decode #(.SEL_W(SEL_W)) u_dec (
    .sel_q (sel_q),
    .lines (lines),
    .multi (multi_sel)
  );

  bsel_gate #(.LINES(LINES)) u_gate (
    .cmd_win  (cmd_win),
    .lines    (lines),
    .bank_cmd (bank_cmd)
  );
endmodule

// File: rtl/bsel_checker.sv
module bsel_checker #(
  parameter int SEL_W = bsel_pkg::DEF_SEL_W,
  localparam int LINES = SEL_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_en,
  input logic [SEL_W-1:0] ld_lo,
  input logic             cmd_win,
  input logic [LINES-1:0] bank_cmd,
  input logic             multi_sel
);
  // R1: in reset an open window shows only line 0
  a_r1_reset_bank0: assert property (@(posedge clk)
    (!rst_n && cmd_win) |-> (bank_cmd == LINES'(1)));

  // R2: without a load the lines hold across consecutive open windows
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_win && !ld_en) |=> (!cmd_win || $stable(bank_cmd)));

  // R3: lines 1..N follow the low accumulator bits loaded one cycle earlier
  a_r3_low_bits_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (!cmd_win || (bank_cmd[LINES-1:1] == $past(ld_lo))));

  // R6: line 0 never shares the bus with another line
  a_r6_line0_alone: assert property (@(posedge clk) disable iff (!rst_n)
    bank_cmd[0] |-> (bank_cmd[LINES-1:1] == '0));

  // R7: closed window means silent lines
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_win |-> (bank_cmd == '0));

  // R8: status agrees with the number of driven lines
  a_r8_multi_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_win |-> (multi_sel == ($countones(bank_cmd) > 1)));
endmodule

bind bank_select_lines bsel_checker #(.SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_en     (ld_en),
  .ld_lo     (ld_val[SEL_W-1:0]),
  .cmd_win   (cmd_win),
  .bank_cmd  (bank_cmd),
  .multi_sel (multi_sel)
);

// File: tb/bank_select_lines_test.sv
module bank_select_lines_test;
  localparam int SEL_W = 3;
  localparam int ACC_W = 4;
  localparam int LINES = SEL_W + 1;
  localparam int NVEC  = 14;

  // Vector: {ld_en, ld_val[3:0], cmd_win, exp_cmd[3:0], exp_multi}
  typedef logic [10:0] vec_t;
  localparam vec_t VECS [NVEC] = '{
    {1'b1, 4'b0001, 1'b1, 4'b0010, 1'b0},  // R4 code 001
    {1'b1, 4'b0010, 1'b1, 4'b0100, 1'b0},  // R4 code 010
    {1'b1, 4'b0100, 1'b1, 4'b1000, 1'b0},  // R4 code 100
    {1'b1, 4'b0000, 1'b1, 4'b0001, 1'b0},  // R4 code 000
    {1'b1, 4'b0011, 1'b1, 4'b0110, 1'b1},  // R5 code 011
    {1'b1, 4'b0111, 1'b1, 4'b1110, 1'b1},  // R5 code 111
    {1'b1, 4'b0101, 1'b1, 4'b1010, 1'b1},  // R5 code 101
    {1'b1, 4'b0110, 1'b0, 4'b0000, 1'b1},  // R7 closed, R8 flag ungated
    {1'b0, 4'b0001, 1'b1, 4'b1100, 1'b1},  // R2 no load keeps 110
    {1'b1, 4'b1001, 1'b1, 4'b0010, 1'b0},  // R3 top bit ignored
    {1'b1, 4'b1000, 1'b1, 4'b0001, 1'b0},  // R3 top bit ignored
    {1'b0, 4'b0111, 1'b0, 4'b0000, 1'b0},  // R7 closed, single bank
    {1'b1, 4'b1111, 1'b1, 4'b1110, 1'b1},  // R5 all bits
    {1'b0, 4'b0000, 1'b1, 4'b1110, 1'b1}   // R2 hold
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ld_en = 1'b0;
  logic [ACC_W-1:0] ld_val = '0;
  logic             cmd_win = 1'b0;
  logic [LINES-1:0] bank_cmd;
  logic             multi_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bank_select_lines #(.SEL_W(SEL_W), .ACC_W(ACC_W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (ld_en),
    .ld_val    (ld_val),
    .cmd_win   (cmd_win),
    .bank_cmd  (bank_cmd),
    .multi_sel (multi_sel)
  );

  task automatic check(input string tag, input logic [LINES-1:0] ec, input logic em);
    n_chk++;
    if (bank_cmd !== ec || multi_sel !== em) begin
      n_bad++;
      $display("FAIL %s: bank_cmd=%b multi_sel=%b expected bank_cmd=%b multi_sel=%b",
               tag, bank_cmd, multi_sel, ec, em);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample mid-low phase.
  task automatic step(input logic le, input logic [ACC_W-1:0] lv, input logic cw);
    @(negedge clk);
    ld_en = le; ld_val = lv; cmd_win = cw;
    @(posedge clk);
    #5;
  endtask

  initial begin
    #4000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, window open while reset held
    cmd_win = 1'b1;
    #35;
    check("R1 in reset", 4'b0001, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    step(1'b0, 4'b0111, 1'b1);
    check("R1 after release", 4'b0001, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i][10], VECS[i][9:6], VECS[i][5]);
      check($sformatf("R%0d-table vec %0d", 0, i), VECS[i][4:1], VECS[i][0]);
    end

    // R6: sweep every code, line 0 only for zero and never alongside others
    for (int v = 0; v < 8; v++) begin
      step(1'b1, 4'(v), 1'b1);
      check("R6 sweep", (v == 0) ? 4'b0001 : {3'(v), 1'b0}, ($countones(v) > 1));
    end

    // R8: flag follows register with window closed
    step(1'b1, 4'b0011, 1'b0);
    check("R8 closed window multi", 4'b0000, 1'b1);
    step(1'b1, 4'b0100, 1'b0);
    check("R8 closed window single", 4'b0000, 1'b0);

    // R1: reset mid-run returns to bank 0
    step(1'b1, 4'b0111, 1'b1);
    @(negedge clk) begin ld_en = 1'b0; rst_n = 1'b0; end
    #5;
    check("R1 mid-run reset", 4'b0001, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    step(1'b0, 4'b0000, 1'b1);
    check("R1 after second release", 4'b0001, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule